// File: doc/BRIEF.md
# Accumulator Execution Unit

This block is a compact execution stage built around three storage registers: an accumulator, one general-purpose register and an output register. Each clock edge at which the valid strobe is high, the unit decodes a 4-bit operation code and performs exactly one register transfer. Loads take a value from the input bus. Moves copy between the registers or into the output register. The arithmetic and logic group combines the accumulator with the general register, or inverts the accumulator.

The operation code comes straight from the surrounding logic. The block has no instruction fetch, no flags and no branching. Results show up on the register outputs one clock after the edge that performs the transfer. A synchronous reset clears all three registers.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, general register and output register are all 0 after that edge, whatever `op_valid` and `op_code` are.
- R2: When `op_valid` is low at an edge, none of the three registers changes.
- R3: Codes 1 and 6 load the accumulator from `in_bus`. The general and output registers keep their values.
- R4: Code 2 copies the accumulator into the general register. The accumulator and output register keep their values.
- R5: Code 5 loads the general register from `in_bus`. The accumulator and output register keep their values.
- R6: Code 3 copies the general register into the output register, and code 4 copies the accumulator into it. The accumulator and general register keep their values under both codes.
- R7: Code 7 writes accumulator plus general register into the accumulator, modulo 2^W (0xFF + 0x01 gives 0x00 at W=8). The other registers keep their values.
- R8: Code 8 writes the bitwise OR and code 9 writes the bitwise AND of accumulator and general register into the accumulator. The other registers keep their values.
- R9: Code 10 writes the bitwise complement of the accumulator into the accumulator. The other registers keep their values.
- R10: Codes 0 and 11 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 4 | Operation code |
| in_bus | input | W | Input data for the load operations |
| acc_o | output | W | Accumulator contents |
| gpr_o | output | W | General register contents |
| out_o | output | W | Output register contents |

## Verification
All three registers are outputs, so a wrong value in any of them appears on the ports one clock after the faulty transfer. A wrong write enable, for example a register written by an operation that should leave it alone, shows up in the same cycle as an unexpected change. A corrupted general register is visible directly, and it also spreads into the accumulator at the next add, OR or AND, and into the output register at the next code 3. The stimulus therefore chains operations so that each stored value is read again by a later operation, and it compares every register after every step.

// File: rtl/acc_exec_pkg.sv
`timescale 1ns/1ps
package acc_exec_pkg;

    // Operation codes; values are fixed by the operation set
    typedef enum logic [3:0] {
        OC_IDLE         = 4'd0,
        OC_ACC_LOAD     = 4'd1,
        OC_ACC_TO_GPR   = 4'd2,
        OC_GPR_TO_OUT   = 4'd3,
        OC_ACC_TO_OUT   = 4'd4,
        OC_GPR_LOAD     = 4'd5,
        OC_ACC_LOAD_ALT = 4'd6,
        OC_SUM          = 4'd7,
        OC_BIT_OR       = 4'd8,
        OC_BIT_AND      = 4'd9,
        OC_INVERT       = 4'd10
    } opcode_e;

    typedef enum logic [1:0] {
        FN_ADD,
        FN_OR,
        FN_AND,
        FN_INV
    } alu_fn_e;

    typedef enum logic {
        ACC_FROM_BUS,
        ACC_FROM_ALU
    } acc_src_e;

    typedef enum logic {
        GPR_FROM_BUS,
        GPR_FROM_ACC
    } gpr_src_e;

    typedef enum logic {
        OUT_FROM_GPR,
        OUT_FROM_ACC
    } out_src_e;

    typedef struct packed {
        logic     acc_we;
        acc_src_e acc_src;
        logic     gpr_we;
        gpr_src_e gpr_src;
        logic     out_we;
        out_src_e out_src;
        alu_fn_e  alu_fn;
    } ctrl_t;

endpackage

// File: rtl/acc_exec_decode.sv
`timescale 1ns/1ps
module acc_exec_decode
    import acc_exec_pkg::*;
(
    input  logic       op_valid,
    input  logic [3:0] op_code,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{acc_we: 1'b0, acc_src: ACC_FROM_BUS, gpr_we: 1'b0,
                 gpr_src: GPR_FROM_BUS, out_we: 1'b0, out_src: OUT_FROM_GPR,
                 alu_fn: FN_ADD};
        if (op_valid) begin
            case (op_code)
                OC_ACC_LOAD, OC_ACC_LOAD_ALT: begin
                    ctrl.acc_we  = 1'b1;
                    ctrl.acc_src = ACC_FROM_BUS;
                end
                OC_ACC_TO_GPR: begin
                    ctrl.gpr_we  = 1'b1;
                    ctrl.gpr_src = GPR_FROM_ACC;
                end
                OC_GPR_LOAD: begin
                    ctrl.gpr_we  = 1'b1;
                    ctrl.gpr_src = GPR_FROM_BUS;
                end
                OC_GPR_TO_OUT: begin
                    ctrl.out_we  = 1'b1;
                    ctrl.out_src = OUT_FROM_GPR;
                end
                OC_ACC_TO_OUT: begin
                    ctrl.out_we  = 1'b1;
                    ctrl.out_src = OUT_FROM_ACC;
                end
                OC_SUM: begin
                    ctrl.acc_we  = 1'b1;
                    ctrl.acc_src = ACC_FROM_ALU;
                    ctrl.alu_fn  = FN_ADD;
                end
                OC_BIT_OR: begin
                    ctrl.acc_we  = 1'b1;
                    ctrl.acc_src = ACC_FROM_ALU;
                    ctrl.alu_fn  = FN_OR;
                end
                OC_BIT_AND: begin
                    ctrl.acc_we  = 1'b1;
                    ctrl.acc_src = ACC_FROM_ALU;
                    ctrl.alu_fn  = FN_AND;
                end
                OC_INVERT: begin
                    ctrl.acc_we  = 1'b1;
                    ctrl.acc_src = ACC_FROM_ALU;
                    ctrl.alu_fn  = FN_INV;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_exec_alu.sv
`timescale 1ns/1ps
module acc_exec_alu
    import acc_exec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_fn_e      fn,
    output logic [W-1:0] res
);

    logic [W-1:0] sum;
    logic [W-1:0] bit_or;
    logic [W-1:0] bit_and;
    logic [W-1:0] bit_inv;

    // Carry out of the top bit is dropped: the sum wraps modulo 2^W
    assign sum = opa + opb;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_or[i]  = opa[i] | opb[i];
        assign bit_and[i] = opa[i] & opb[i];
        assign bit_inv[i] = ~opa[i];
    end

    always_comb begin
        case (fn)
            FN_ADD:  res = sum;
            FN_OR:   res = bit_or;
            FN_AND:  res = bit_and;
            default: res = bit_inv;
        endcase
    end

endmodule

// File: rtl/acc_exec_unit.sv
`timescale 1ns/1ps
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] in_bus,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] gpr_o,
    output logic [W-1:0] out_o
);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] gpr;
        logic [W-1:0] out;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    ctrl_t        ctrl;
    logic [W-1:0] alu_res;

    acc_exec_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctrl     (ctrl)
    );

    acc_exec_alu #(.W(W)) u_alu (
        .opa (st_q.acc),
        .opb (st_q.gpr),
        .fn  (ctrl.alu_fn),
        .res (alu_res)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl.acc_we) begin
            st_d.acc = (ctrl.acc_src == ACC_FROM_ALU) ? alu_res : in_bus;
        end
        if (ctrl.gpr_we) begin
            st_d.gpr = (ctrl.gpr_src == GPR_FROM_ACC) ? st_q.acc : in_bus;
        end
        if (ctrl.out_we) begin
            st_d.out = (ctrl.out_src == OUT_FROM_ACC) ? st_q.acc : st_q.gpr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
    assign gpr_o = st_q.gpr;
    assign out_o = st_q.out;

endmodule

// File: rtl/acc_exec_unit_chk.sv
`timescale 1ns/1ps
module acc_exec_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] in_bus,
    input logic [W-1:0] acc_o,
    input logic [W-1:0] gpr_o,
    input logic [W-1:0] out_o
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && gpr_o == '0 && out_o == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_o) && $stable(gpr_o) && $stable(out_o)));

    p_acc_load_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 4'd1 || op_code == 4'd6))
        |=> (acc_o == $past(in_bus) && $stable(gpr_o) && $stable(out_o)));

    p_gpr_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd2)
        |=> (gpr_o == $past(acc_o) && $stable(acc_o)));

    p_out_from_gpr_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd3)
        |=> (out_o == $past(gpr_o) && $stable(acc_o) && $stable(gpr_o)));

    p_sum_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd7)
        |=> (acc_o == W'($past(acc_o) + $past(gpr_o))));

    p_unused_codes_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 4'd0 || op_code > 4'd10))
        |=> ($stable(acc_o) && $stable(gpr_o) && $stable(out_o)));

endmodule

bind acc_exec_unit acc_exec_unit_chk #(.W(W)) u_chk (.*);

// File: tb/acc_exec_unit_test.sv
`timescale 1ns/1ps
module acc_exec_unit_test;

    localparam int W = 8;

    typedef struct packed {
        logic         vld;
        logic [3:0]   code;
        logic [W-1:0] din;
        logic [W-1:0] exp_acc;
        logic [W-1:0] exp_gpr;
        logic [W-1:0] exp_out;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1,  8'h3C, 8'h3C, 8'h00, 8'h00},
        '{1'b1, 4'd2,  8'hFF, 8'h3C, 8'h3C, 8'h00},
        '{1'b1, 4'd5,  8'h0F, 8'h3C, 8'h0F, 8'h00},
        '{1'b1, 4'd7,  8'h00, 8'h4B, 8'h0F, 8'h00},
        '{1'b1, 4'd3,  8'h00, 8'h4B, 8'h0F, 8'h0F},
        '{1'b1, 4'd4,  8'h00, 8'h4B, 8'h0F, 8'h4B},
        '{1'b1, 4'd8,  8'hAA, 8'h4F, 8'h0F, 8'h4B},
        '{1'b1, 4'd9,  8'h00, 8'h0F, 8'h0F, 8'h4B},
        '{1'b1, 4'd10, 8'h00, 8'hF0, 8'h0F, 8'h4B},
        '{1'b1, 4'd6,  8'hC8, 8'hC8, 8'h0F, 8'h4B},
        '{1'b1, 4'd5,  8'h50, 8'hC8, 8'h50, 8'h4B},
        '{1'b1, 4'd7,  8'h00, 8'h18, 8'h50, 8'h4B},
        '{1'b0, 4'd1,  8'h77, 8'h18, 8'h50, 8'h4B},
        '{1'b0, 4'd5,  8'h77, 8'h18, 8'h50, 8'h4B},
        '{1'b1, 4'd0,  8'h77, 8'h18, 8'h50, 8'h4B},
        '{1'b1, 4'd11, 8'h77, 8'h18, 8'h50, 8'h4B},
        '{1'b1, 4'd15, 8'h77, 8'h18, 8'h50, 8'h4B},
        '{1'b1, 4'd4,  8'h00, 8'h18, 8'h50, 8'h18},
        '{1'b1, 4'd10, 8'h00, 8'hE7, 8'h50, 8'h18},
        '{1'b1, 4'd2,  8'h00, 8'hE7, 8'hE7, 8'h18}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = 4'd0;
    logic [W-1:0] in_bus = '0;
    logic [W-1:0] acc_o;
    logic [W-1:0] gpr_o;
    logic [W-1:0] out_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_exec_unit #(.W(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .in_bus   (in_bus),
        .acc_o    (acc_o),
        .gpr_o    (gpr_o),
        .out_o    (out_o)
    );

    function automatic string req_of(input logic v, input logic [3:0] c);
        if (!v) return "R2";
        case (c)
            4'd1, 4'd6: return "R3";
            4'd2:       return "R4";
            4'd5:       return "R5";
            4'd3, 4'd4: return "R6";
            4'd7:       return "R7";
            4'd8, 4'd9: return "R8";
            4'd10:      return "R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic compare(input string req, input logic [W-1:0] ea,
                           input logic [W-1:0] eg, input logic [W-1:0] eo);
        checks++;
        if (acc_o !== ea || gpr_o !== eg || out_o !== eo) begin
            errors++;
            $display("FAIL %s: acc=%h gpr=%h out=%h expected acc=%h gpr=%h out=%h",
                     req, acc_o, gpr_o, out_o, ea, eg, eo);
        end
    endtask

    // Apply inputs 1 ns after an edge, sample 1 ns after the next one
    task automatic step(input logic v, input logic [3:0] c, input logic [W-1:0] d);
        op_valid = v;
        op_code  = c;
        in_bus   = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        compare("R1", 8'h00, 8'h00, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].vld, VEC[i].code, VEC[i].din);
            compare(req_of(VEC[i].vld, VEC[i].code),
                    VEC[i].exp_acc, VEC[i].exp_gpr, VEC[i].exp_out);
        end

        // R7: sum wraps at the top value
        step(1'b1, 4'd6, 8'hFF);
        compare("R3", 8'hFF, 8'hE7, 8'h18);
        step(1'b1, 4'd5, 8'h01);
        compare("R5", 8'hFF, 8'h01, 8'h18);
        step(1'b1, 4'd7, 8'h00);
        compare("R7", 8'h00, 8'h01, 8'h18);
        // R8: AND against all ones
        step(1'b1, 4'd1, 8'hFF);
        compare("R3", 8'hFF, 8'h01, 8'h18);
        step(1'b1, 4'd9, 8'h00);
        compare("R8", 8'h01, 8'h01, 8'h18);
        step(1'b1, 4'd3, 8'h00);
        compare("R6", 8'h01, 8'h01, 8'h01);

        // R1: reset wins over a valid load
        rst = 1'b1;
        step(1'b1, 4'd1, 8'h55);
        compare("R1", 8'h00, 8'h00, 8'h00);
        rst = 1'b0;
        step(1'b0, 4'd0, 8'h00);
        compare("R1", 8'h00, 8'h00, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: acc=%h gpr=%h out=%h expected run to end",
                         acc_o, gpr_o, out_o);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule